// File: doc/BRIEF.md
# Multi-Channel Raster Sync Generator

This block is a free-running raster timer for a display pipeline. A sample counter walks across each line and a line counter walks down the frame, each wrapping at a programmed total. From these two counters the block derives four independent horizontal/vertical sync pairs. Each pair has its own edge positions, so every downstream video path can get sync edges that are shifted early or late to absorb that path's own pipeline latency. The block also raises a flag over a programmed rectangle of active picture, and pulses once at the top of every frame so an interrupt block can count frames.

Software programs the block through a single-cycle write port. All geometry writes land in shadow registers and are copied into the working set only when a new frame begins, so a frame that is already being scanned is never torn. A restart write forces the counters to the top of frame at once. A nonzero run-control value parks the counters at the top of frame.

Top module: `video_timing_gen`

## Requirements
- R1: The sample counter `pix_o` counts from 0 to L-1 and then wraps to 0, where L is the value in bits 15:0 of register 1.
- R2: The line counter `line_o` starts at 1, advances when the sample counter wraps, and after line H/2 returns to 1, where H is the half-line count written to register 2 (bit 0 ignored).
- R3: `frame_start_o` is high for exactly the cycles in which the counters newly sit at sample 0 of line 1 because of a frame wrap or a restart.
- R4: A write to register 3 with bit 0 set moves the counters to sample 0 of line 1 on the same clock edge; with bit 0 clear it has no effect.
- R5: Register 0 holds the run control: 0 lets the counters run; any nonzero value holds them at sample 0 of line 1 with `frame_start_o` low.
- R6: Channel c's horizontal register is at address 8+4c with the stop sample in bits 31:16 and the start sample in bits 15:0; `hsync_o[c]` is high for start <= sample < stop, wraps past the line end when start > stop, and stays low when they are equal.
- R7: Channel c's vertical line register (8+4c+1) and offset register (8+4c+2) each hold the falling-edge value in bits 31:16 and the rising-edge value in bits 15:0; `vsync_o[c]` is high from the rising (line, sample) position up to but excluding the falling one, spans the frame boundary when the rise comes later in the frame than the fall, and stays low when they coincide.
- R8: Register 4 (window start) and register 5 (window stop) hold a line in bits 31:16 and a sample in bits 15:0; `active_o` is high when the line and sample both lie inside these inclusive bounds.
- R9: Writes to registers 6 and 7 (bottom-field window copies) have no effect on any output.
- R10: Writes to registers 1, 2, 4, 5 and the channel registers take effect at the next frame start (wrap or restart), never within the current frame.
- R11: During reset the counters show sample 0, line 1, every sync output, `active_o` and `frame_start_o` are low, and the line length and line count return to their parameter defaults.
- R12: All outputs are registered and change on the same clock edge as the counters they are derived from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| hsync_o | output | NUM_CH | Horizontal sync, one per channel |
| vsync_o | output | NUM_CH | Vertical sync, one per channel |
| active_o | output | 1 | Active picture window flag |
| frame_start_o | output | 1 | One-cycle top-of-frame event |
| pix_o | output | 16 | Current sample position in the line |
| line_o | output | 16 | Current line number, counted from 1 |

## Verification
On every cycle the assertions hold the counters inside their programmed ranges, tie the frame event to the top-of-frame position, keep the counters parked while run control is nonzero, keep the working configuration frozen away from the top of frame, and keep each sync and the window low or inside bounds when their edges say so. Exact sync edge placement, including horizontal wrap and vertical pulses that straddle the frame boundary, the deferral of a mid-frame write to the following frame, restart timing and the inertness of the bottom-field window registers only show up in the bench scenarios, which compare every output each cycle against a position-based model.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;
    parameter int CW = 16;
    parameter int DW = 2 * CW;

    typedef logic [CW-1:0] crd_t;

    // hi half: stop / fall / line ; lo half: start / rise / sample
    typedef struct packed {
        crd_t hi;
        crd_t lo;
    } pair_t;

    typedef struct packed {
        pair_t hs;
        pair_t vline;
        pair_t voff;
    } chan_cfg_t;

    typedef struct packed {
        crd_t  clocks;
        crd_t  lines;
        pair_t win_lo;
        pair_t win_hi;
    } frame_cfg_t;

    typedef struct packed {
        crd_t line;
        crd_t pix;
    } pos_t;

    localparam int REG_MODE      = 0;
    localparam int REG_CLKS      = 1;
    localparam int REG_HALF      = 2;
    localparam int REG_RESYNC    = 3;
    localparam int REG_WIN_T0    = 4;
    localparam int REG_WIN_T1    = 5;
    localparam int REG_WIN_B0    = 6;
    localparam int REG_WIN_B1    = 7;
    localparam int REG_CH_BASE   = 8;
    localparam int REG_CH_STRIDE = 4;

    // Half-open span [a, b) that may wrap past the end of the line.
    function automatic logic in_span(input crd_t v, input crd_t a, input crd_t b);
        logic r;
        if (a == b)
            r = 1'b0;
        else if (a < b)
            r = (v >= a) && (v < b);
        else
            r = (v >= a) || (v < b);
        return r;
    endfunction

    // Position p is at or beyond (l, o) in scan order.
    function automatic logic reached(input pos_t p, input crd_t l, input crd_t o);
        return (p.line > l) || ((p.line == l) && (p.pix >= o));
    endfunction

    // (l0, o0) comes strictly before (l1, o1) in scan order.
    function automatic logic earlier(input crd_t l0, input crd_t o0,
                                     input crd_t l1, input crd_t o1);
        return (l0 < l1) || ((l0 == l1) && (o0 < o1));
    endfunction
endpackage

// File: rtl/vtg_cfg_regs.sv
`timescale 1ns/1ps
module vtg_cfg_regs
    import vtg_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 5,
    parameter int DEF_CLKS  = 16,
    parameter int DEF_LINES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              load,
    output logic              run,
    output logic              resync,
    output frame_cfg_t        nxt_frame,
    output frame_cfg_t        act_frame,
    output chan_cfg_t         nxt_chan [NUM_CH],
    output chan_cfg_t         act_chan [NUM_CH]
);
    localparam frame_cfg_t FRAME_RST = '{clocks: CW'(DEF_CLKS), lines: CW'(DEF_LINES),
                                         win_lo: '0, win_hi: '0};

    logic [31:0] addr32;
    logic        hold_q;
    frame_cfg_t  sh_frame, act_q;

    assign addr32 = 32'(addr);
    assign run    = !hold_q;
    assign resync = we && (addr32 == REG_RESYNC) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= 1'b0;
            sh_frame <= FRAME_RST;
        end else if (we) begin
            case (addr32)
                REG_MODE:   hold_q          <= (wdata != '0);
                REG_CLKS:   sh_frame.clocks <= wdata[CW-1:0];
                REG_HALF:   sh_frame.lines  <= wdata[CW:1];
                REG_WIN_T0: sh_frame.win_lo <= wdata;
                REG_WIN_T1: sh_frame.win_hi <= wdata;
                REG_WIN_B0, REG_WIN_B1: ;  // progressive only: bottom copies are inert
                default: ;
            endcase
        end
    end

    assign nxt_frame = load ? sh_frame : act_q;
    assign act_frame = act_q;

    always_ff @(posedge clk) begin
        if (rst) act_q <= FRAME_RST;
        else     act_q <= nxt_frame;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int BASE = REG_CH_BASE + c * REG_CH_STRIDE;
        chan_cfg_t sh_q, cur_q, nxt;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q <= '0;
            end else if (we) begin
                if (addr32 == BASE)          sh_q.hs    <= wdata;
                else if (addr32 == BASE + 1) sh_q.vline <= wdata;
                else if (addr32 == BASE + 2) sh_q.voff  <= wdata;
            end
        end

        assign nxt = load ? sh_q : cur_q;

        always_ff @(posedge clk) begin
            if (rst) cur_q <= '0;
            else     cur_q <= nxt;
        end

        assign nxt_chan[c] = nxt;
        assign act_chan[c] = cur_q;
    end
endmodule

// File: rtl/vtg_raster.sv
`timescale 1ns/1ps
module vtg_raster
    import vtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic resync,
    input  crd_t clocks,
    input  crd_t lines,
    output pos_t pos,
    output pos_t nxt_pos,
    output logic load,
    output logic frame_start
);
    localparam pos_t TOP = '{line: CW'(1), pix: '0};

    logic pix_end, line_end, fs_n;

    always_comb begin
        pix_end  = pos.pix >= (clocks - CW'(1));
        line_end = pos.line >= lines;
        nxt_pos  = pos;
        load     = 1'b0;
        fs_n     = 1'b0;
        if (!run) begin
            nxt_pos = TOP;
            load    = 1'b1;
        end else if (resync || (pix_end && line_end)) begin
            nxt_pos = TOP;
            load    = 1'b1;
            fs_n    = 1'b1;
        end else if (pix_end) begin
            nxt_pos.pix  = '0;
            nxt_pos.line = pos.line + CW'(1);
        end else begin
            nxt_pos.pix = pos.pix + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos         <= TOP;
            frame_start <= 1'b0;
        end else begin
            pos         <= nxt_pos;
            frame_start <= fs_n;
        end
    end

    assert_pix_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        pos.pix < clocks);
    assert_line_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        (pos.line >= CW'(1)) && (pos.line <= lines));
    assert_event_at_top_R3: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (pos.pix == '0) && (pos.line == CW'(1)));
    assert_hold_parks_R5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pos.pix == '0) && (pos.line == CW'(1)) && !frame_start);
endmodule

// File: rtl/vtg_sync_chan.sv
`timescale 1ns/1ps
module vtg_sync_chan
    import vtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pos_t      nxt_pos,
    input  chan_cfg_t nxt_cfg,
    input  chan_cfg_t cur_cfg,
    output logic      hsync,
    output logic      vsync
);
    logic hs_n, vs_n, past_rise, past_fall, rise_first, same;

    always_comb begin
        hs_n       = in_span(nxt_pos.pix, nxt_cfg.hs.lo, nxt_cfg.hs.hi);
        past_rise  = reached(nxt_pos, nxt_cfg.vline.lo, nxt_cfg.voff.lo);
        past_fall  = reached(nxt_pos, nxt_cfg.vline.hi, nxt_cfg.voff.hi);
        rise_first = earlier(nxt_cfg.vline.lo, nxt_cfg.voff.lo,
                             nxt_cfg.vline.hi, nxt_cfg.voff.hi);
        same       = (nxt_cfg.vline.lo == nxt_cfg.vline.hi) &&
                     (nxt_cfg.voff.lo == nxt_cfg.voff.hi);
        if (same)
            vs_n = 1'b0;
        else if (rise_first)
            vs_n = past_rise && !past_fall;
        else
            vs_n = past_rise || !past_fall;  // pulse straddles the frame boundary
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync <= 1'b0;
            vsync <= 1'b0;
        end else begin
            hsync <= hs_n;
            vsync <= vs_n;
        end
    end

    assert_hs_empty_low_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_cfg.hs.lo == cur_cfg.hs.hi) |-> !hsync);
    assert_vs_empty_low_R7: assert property (@(posedge clk) disable iff (rst)
        ((cur_cfg.vline.lo == cur_cfg.vline.hi) && (cur_cfg.voff.lo == cur_cfg.voff.hi))
        |-> !vsync);
endmodule

// File: rtl/vtg_window.sv
`timescale 1ns/1ps
module vtg_window
    import vtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pos_t  nxt_pos,
    input  pair_t nxt_lo,
    input  pair_t nxt_hi,
    input  pos_t  cur_pos,
    input  pair_t cur_lo,
    input  pair_t cur_hi,
    output logic  active
);
    logic act_n;

    always_comb begin
        act_n = (nxt_pos.line >= nxt_lo.hi) && (nxt_pos.line <= nxt_hi.hi) &&
                (nxt_pos.pix  >= nxt_lo.lo) && (nxt_pos.pix  <= nxt_hi.lo);
    end

    always_ff @(posedge clk) begin
        if (rst) active <= 1'b0;
        else     active <= act_n;
    end

    assert_window_rows_R8: assert property (@(posedge clk) disable iff (rst)
        active |-> (cur_pos.line >= cur_lo.hi) && (cur_pos.line <= cur_hi.hi));
    assert_window_cols_R8: assert property (@(posedge clk) disable iff (rst)
        active |-> (cur_pos.pix >= cur_lo.lo) && (cur_pos.pix <= cur_hi.lo));
endmodule

// File: rtl/video_timing_gen.sv
`timescale 1ns/1ps
module video_timing_gen
    import vtg_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DEF_CLKS  = 16,
    parameter int DEF_LINES = 4,
    parameter int ADDR_W    = $clog2(REG_CH_BASE + REG_CH_STRIDE * NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [NUM_CH-1:0] hsync_o,
    output logic [NUM_CH-1:0] vsync_o,
    output logic              active_o,
    output logic              frame_start_o,
    output logic [CW-1:0]     pix_o,
    output logic [CW-1:0]     line_o
);
    logic       run, resync, load;
    frame_cfg_t nxt_frame, act_frame;
    chan_cfg_t  nxt_chan [NUM_CH];
    chan_cfg_t  act_chan [NUM_CH];
    pos_t       pos, nxt_pos;

    vtg_cfg_regs #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DEF_CLKS(DEF_CLKS), .DEF_LINES(DEF_LINES)
    ) i_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .load(load), .run(run), .resync(resync),
        .nxt_frame(nxt_frame), .act_frame(act_frame),
        .nxt_chan(nxt_chan), .act_chan(act_chan)
    );

    vtg_raster i_raster (
        .clk(clk), .rst(rst), .run(run), .resync(resync),
        .clocks(act_frame.clocks), .lines(act_frame.lines),
        .pos(pos), .nxt_pos(nxt_pos), .load(load), .frame_start(frame_start_o)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sync
        vtg_sync_chan i_chan (
            .clk(clk), .rst(rst), .nxt_pos(nxt_pos),
            .nxt_cfg(nxt_chan[c]), .cur_cfg(act_chan[c]),
            .hsync(hsync_o[c]), .vsync(vsync_o[c])
        );

        assert_chan_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
            !((pos.pix == '0) && (pos.line == CW'(1))) |-> $stable(act_chan[c]));
    end

    vtg_window i_window (
        .clk(clk), .rst(rst), .nxt_pos(nxt_pos),
        .nxt_lo(nxt_frame.win_lo), .nxt_hi(nxt_frame.win_hi),
        .cur_pos(pos), .cur_lo(act_frame.win_lo), .cur_hi(act_frame.win_hi),
        .active(active_o)
    );

    assign pix_o  = pos.pix;
    assign line_o = pos.line;

    assert_frame_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !((pos.pix == '0) && (pos.line == CW'(1))) |-> $stable(act_frame));
endmodule

// File: tb/test_video_timing_gen.sv
`timescale 1ns/1ps
module test_video_timing_gen;
    localparam int  NCH    = 4;
    localparam int  AW     = 5;
    localparam int  NREG   = 24;
    localparam time CLK_P  = 8ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [NCH-1:0] hsync_o, vsync_o;
    logic          active_o, frame_start_o;
    logic [15:0]   pix_o, line_o;

    int n_checks = 0;
    int n_err    = 0;

    // bench model of the raster, built from the requirements
    logic [31:0] sh_img [NREG];
    logic [31:0] ac_img [NREG];
    int  m_pix, m_line;
    bit  m_fs, m_hold;

    always #(CLK_P/2) clk = ~clk;

    video_timing_gen #(.NUM_CH(NCH), .DEF_CLKS(16), .DEF_LINES(4)) i_video_timing_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .active_o(active_o),
        .frame_start_o(frame_start_o), .pix_o(pix_o), .line_o(line_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (line %0d pix %0d)",
                     req, act, exp, m_line, m_pix);
        end
    endtask

    function automatic int len();
        return int'(ac_img[1][15:0]);
    endfunction

    function automatic bit exp_hs(input int c);
        int s, e, l;
        l = len();
        s = int'(ac_img[8 + 4*c][15:0]);
        e = int'(ac_img[8 + 4*c][31:16]);
        if (s == e) return 1'b0;
        return ((m_pix - s + l) % l) < ((e - s + l) % l);
    endfunction

    function automatic bit exp_vs(input int c);
        int l, p, rp, fp;
        l  = len();
        p  = (m_line - 1) * l + m_pix;
        rp = (int'(ac_img[9 + 4*c][15:0])  - 1) * l + int'(ac_img[10 + 4*c][15:0]);
        fp = (int'(ac_img[9 + 4*c][31:16]) - 1) * l + int'(ac_img[10 + 4*c][31:16]);
        if (rp == fp) return 1'b0;
        if (rp < fp)  return (p >= rp) && (p < fp);
        return (p >= rp) || (p < fp);
    endfunction

    function automatic bit exp_act();
        return (m_line >= int'(ac_img[4][31:16])) && (m_line <= int'(ac_img[5][31:16])) &&
               (m_pix  >= int'(ac_img[4][15:0]))  && (m_pix  <= int'(ac_img[5][15:0]));
    endfunction

    // R12: every output is compared against the model state of the same cycle
    task automatic compare_all();
        check(int'(pix_o) == m_pix, "R1 sample counter", int'(pix_o), m_pix);
        check(int'(line_o) == m_line, "R2 line counter", int'(line_o), m_line);
        check(frame_start_o == m_fs, "R3 frame event", int'(frame_start_o), int'(m_fs));
        for (int c = 0; c < NCH; c++) begin
            check(hsync_o[c] == exp_hs(c), $sformatf("R6 hsync ch%0d", c),
                  int'(hsync_o[c]), int'(exp_hs(c)));
            check(vsync_o[c] == exp_vs(c), $sformatf("R7 vsync ch%0d", c),
                  int'(vsync_o[c]), int'(exp_vs(c)));
        end
        check(active_o == exp_act(), "R8 window", int'(active_o), int'(exp_act()));
    endtask

    task automatic model_edge(input bit we, input int addr, input logic [31:0] data);
        int l, nl;
        l  = len();
        nl = int'(ac_img[2][16:1]);
        if (m_hold) begin
            m_pix = 0; m_line = 1; m_fs = 1'b0; ac_img = sh_img;
        end else if ((we && addr == 3 && data[0]) || (m_pix >= l - 1 && m_line >= nl)) begin
            m_pix = 0; m_line = 1; m_fs = 1'b1; ac_img = sh_img;
        end else if (m_pix >= l - 1) begin
            m_pix = 0; m_line++; m_fs = 1'b0;
        end else begin
            m_pix++; m_fs = 1'b0;
        end
        if (we) begin
            if (addr == 0)
                m_hold = (data != 0);
            else if (addr == 1 || addr == 2 || addr == 4 || addr == 5 ||
                     (addr >= 8 && addr < NREG && ((addr - 8) % 4) < 3))
                sh_img[addr] = data;
        end
    endtask

    // one clock: compare at the falling edge, drive, advance model at the rising edge
    task automatic step(input bit we, input int addr, input logic [31:0] data);
        compare_all();
        cfg_we    = we;
        cfg_addr  = addr[AW-1:0];
        cfg_wdata = data;
        @(posedge clk);
        model_edge(we, addr, data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 32'd0);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        step(1'b1, addr, data);
    endtask

    task automatic test_reset();
        for (int i = 0; i < NREG; i++) begin
            sh_img[i] = '0;
            ac_img[i] = '0;
        end
        sh_img[1] = 32'd16; sh_img[2] = 32'd8;
        ac_img[1] = 32'd16; ac_img[2] = 32'd8;
        m_pix = 0; m_line = 1; m_fs = 1'b0; m_hold = 1'b0;
        repeat (3) @(negedge clk);
        check(pix_o == 16'd0 && line_o == 16'd1, "R11 reset position",
              int'({line_o, pix_o}), 32'h0001_0000);
        check(hsync_o == '0 && vsync_o == '0, "R11 reset syncs",
              int'({hsync_o, vsync_o}), 0);
        check(!active_o && !frame_start_o, "R11 reset flags",
              int'({active_o, frame_start_o}), 0);
        rst = 1'b0;
        idle(40);  // default geometry: 16 samples by 4 lines
    endtask

    task automatic test_basic();
        wr(1, 32'd20);
        wr(2, 32'd12);
        wr(4, {16'd2, 16'd3});
        wr(5, {16'd4, 16'd12});
        wr(8,  {16'd5, 16'd2});   wr(9,  {16'd2, 16'd1});  wr(10, {16'd5, 16'd5});
        wr(12, {16'd3, 16'd17});  wr(13, {16'd1, 16'd6});  wr(14, {16'd10, 16'd15});
        wr(17, {16'd3, 16'd3});   wr(18, {16'd0, 16'd0});
        wr(20, {16'd19, 16'd10}); wr(21, {16'd4, 16'd2});  wr(22, {16'd2, 16'd18});
        wr(3, 32'd1);
        check(m_pix == 0 && frame_start_o, "R3 event after restart",
              int'(frame_start_o), 1);
        idle(2 * 120 + 5);
    endtask

    task automatic test_deferred();
        while (!(m_line == 3 && m_pix == 7)) idle(1);
        wr(8, {16'd9, 16'd6});
        wr(1, 32'd24);
        while (m_pix != 3) idle(1);
        check(hsync_o[0] == 1'b1, "R10 old hsync kept in current frame", int'(hsync_o[0]), 1);
        while (!m_fs) idle(1);
        while (m_pix != 3) idle(1);
        check(hsync_o[0] == 1'b0, "R10 new hsync after frame start", int'(hsync_o[0]), 0);
        while (m_pix != 7) idle(1);
        check(hsync_o[0] == 1'b1, "R10 new hsync window", int'(hsync_o[0]), 1);
        check(m_line == 1, "R10 change landed in new frame", m_line, 1);
        idle(150);
    endtask

    task automatic test_resync();
        idle(37);
        wr(3, 32'd0);
        check(!(pix_o == 16'd0 && line_o == 16'd1) && !frame_start_o,
              "R4 clear bit ignored", int'(pix_o), m_pix);
        idle(5);
        wr(3, 32'd1);
        check(pix_o == 16'd0 && line_o == 16'd1 && frame_start_o,
              "R4 restart position", int'({line_o, pix_o}), 32'h0001_0000);
        idle(30);
    endtask

    task automatic test_mode();
        wr(0, 32'd2);
        idle(10);
        check(pix_o == 16'd0 && line_o == 16'd1 && !frame_start_o,
              "R5 counters parked", int'({line_o, pix_o}), 32'h0001_0000);
        wr(0, 32'd0);
        idle(5);
        check(pix_o == 16'd5 && line_o == 16'd1, "R5 counters resume",
              int'(pix_o), 5);
        idle(20);
    endtask

    task automatic test_bottom();
        int cnt;
        wr(6, {16'd1, 16'd0});
        wr(7, {16'd6, 16'd23});
        wr(3, 32'd1);
        cnt = 0;
        for (int i = 0; i < 144; i++) begin
            if (active_o) cnt++;
            idle(1);
        end
        check(cnt == 30, "R9 bottom window ignored", cnt, 30);
        idle(10);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_basic();
        test_deferred();
        test_resync();
        test_mode();
        test_bottom();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule